// File: doc/BRIEF.md
# Vector Pairwise Widening Add and Accumulate Unit

This execution unit handles one family of vector instructions: adjacent elements of a source vector are summed in pairs, and each sum is stored in a result element twice as wide as the inputs. A sign bit in the instruction word picks sign extension or zero extension of the inputs. An accumulate bit adds each pair sum onto the matching element of the current destination vector, and that addition wraps at the widened element width. A width bit picks a 128-bit operation or a 64-bit operation. In the 64-bit form only the low half of the source is used and the upper half of the result is cleared.

The surrounding pipeline presents an instruction word with the source and destination register contents and raises `in_valid`. The unit decodes the word at once and shows on `dec_match` whether the word belongs to this family. One clock later it registers the result together with the register indices and a valid flag. An encoding with the reserved element size sets an illegal flag instead of the valid flag. Words that do not match produce nothing, and the output register keeps its previous contents.

Top module: `vpa_unit`

## Requirements
- R1: `dec_match` is high, combinationally, exactly when the instruction word has bit 31 = 0, bits 28:24 = 01110, bit 21 = 1, bits 20:16 = 00000, bit 15 = 0 and bits 13:10 = 1010. Bits 30 (width), 29 (unsigned), 23:22 (size), 14 (accumulate), 9:5 (source index) and 4:0 (destination index) may take any value.
- R2: With size 0 (bytes), result halfword i is byte 2i plus byte 2i+1, and a 128-bit operation (bit 30 = 1) gives 8 results.
- R3: With bit 29 = 0, the source elements are sign-extended to twice their width before the add.
- R4: With bit 29 = 1, the source elements are zero-extended to twice their width before the add.
- R5: With bit 14 = 1, destination element i, read at the doubled width, is added to the pair sum, and the total wraps modulo 2 to the power of the doubled width.
- R6: With bit 30 = 0, the upper 64 source bits have no effect and the upper 64 result bits are zero.
- R7: Size 1 (16-bit elements) gives 32-bit results and size 2 (32-bit elements) gives 64-bit results, both computed by the same pair rule.
- R8: A matching word with size 3 sets `out_illegal` on the next clock, keeps `out_valid` low and leaves `out_result` unchanged.
- R9: A word that does not match, or a cycle with `in_valid` low, keeps `out_valid` and `out_illegal` low on the next clock and leaves `out_result` unchanged.
- R10: A valid, legal, matching input appears on `out_result`, `out_rn` and `out_rd` with `out_valid` high exactly one clock later.
- R11: A synchronous active-high `rst` clears `out_valid`, `out_illegal`, `out_result`, `out_rn` and `out_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_insn | input | 32 | Instruction word |
| in_src | input | 128 | Source vector contents |
| in_dst | input | 128 | Current destination vector contents |
| dec_match | output | 1 | Combinational: word belongs to this instruction family |
| out_valid | output | 1 | Registered result is new this cycle |
| out_illegal | output | 1 | Previous input matched but used the reserved size |
| out_result | output | 128 | Registered result vector |
| out_rn | output | 5 | Source register index of the registered result |
| out_rd | output | 5 | Destination register index of the registered result |

## Verification
Elements of all ones tell sign extension apart from zero extension at every size: the pair sum is 1FE-style with zero extension and FFFE-style with sign extension. Accumulation is tried with a destination of all ones, so that a wrong widened width or a missing wrap shows up, and with mixed nonzero patterns, so that lane misalignment shows up. The 64-bit form is driven with nonzero upper source and destination halves, which exposes any leakage into the cleared half. Reserved-size words and words with one pattern bit flipped are placed right after good results to show that the held output really stays unchanged.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
    localparam int INSN_W    = 32;
    localparam int REG_IDX_W = 5;
    localparam int SIZE_W    = 2;

    // fixed opcode fields of the pairwise widening add family
    localparam logic [4:0] OPC_HI  = 5'b01110;
    localparam logic [4:0] OPC_MID = 5'b00000;
    localparam logic [3:0] OPC_LO  = 4'b1010;

    typedef struct packed {
        logic                  match;
        logic                  wide;   // 128-bit form
        logic                  uns;    // zero extension
        logic                  acc;    // accumulate into destination
        logic [SIZE_W-1:0]     size;
        logic [REG_IDX_W-1:0]  rn;
        logic [REG_IDX_W-1:0]  rd;
    } vpa_dec_t;
endpackage

// File: rtl/vpa_decode.sv
module vpa_decode
    import vpa_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output vpa_dec_t          dec
);
    always_comb begin
        dec.match = (insn[31] == 1'b0)
                 && (insn[28:24] == OPC_HI)
                 && (insn[21] == 1'b1)
                 && (insn[20:16] == OPC_MID)
                 && (insn[15] == 1'b0)
                 && (insn[13:10] == OPC_LO);
        dec.wide  = insn[30];
        dec.uns   = insn[29];
        dec.acc   = insn[14];
        dec.size  = insn[23:22];
        dec.rn    = insn[9:5];
        dec.rd    = insn[4:0];
    end
endmodule

// File: rtl/vpa_pair_lanes.sv
module vpa_pair_lanes #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8
) (
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] dst,
    input  logic             uns,
    input  logic             acc,
    output logic [VEC_W-1:0] res
);
    localparam int WIDE_W  = 2 * ELEM_W;
    localparam int N_PAIRS = VEC_W / WIDE_W;

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        logic [ELEM_W-1:0] lo_d, hi_d;
        logic [WIDE_W-1:0] lo_ext_d, hi_ext_d, addend_d, sum_d;

        always_comb begin
            lo_d     = src[(2*p)*ELEM_W +: ELEM_W];
            hi_d     = src[(2*p+1)*ELEM_W +: ELEM_W];
            lo_ext_d = {{ELEM_W{lo_d[ELEM_W-1] & ~uns}}, lo_d};
            hi_ext_d = {{ELEM_W{hi_d[ELEM_W-1] & ~uns}}, hi_d};
            addend_d = acc ? dst[p*WIDE_W +: WIDE_W] : '0;
            sum_d    = lo_ext_d + hi_ext_d + addend_d;
        end

        assign res[p*WIDE_W +: WIDE_W] = sum_d;
    end
endmodule

// File: rtl/vpa_unit.sv
module vpa_unit
    import vpa_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int BASE_W = 8,
    parameter int N_SIZE = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSN_W-1:0]    in_insn,
    input  logic [VEC_W-1:0]     in_src,
    input  logic [VEC_W-1:0]     in_dst,
    output logic                 dec_match,
    output logic                 out_valid,
    output logic                 out_illegal,
    output logic [VEC_W-1:0]     out_result,
    output logic [REG_IDX_W-1:0] out_rn,
    output logic [REG_IDX_W-1:0] out_rd
);
    localparam int HALF_W = VEC_W / 2;

    typedef struct packed {
        logic                 valid;
        logic                 illegal;
        logic [VEC_W-1:0]     result;
        logic [REG_IDX_W-1:0] rn;
        logic [REG_IDX_W-1:0] rd;
    } unit_state_t;

    vpa_dec_t    dec;
    unit_state_t st_d, st_q;
    logic [VEC_W-1:0] lane_res [N_SIZE];
    logic [VEC_W-1:0] sel_res_d;
    logic             size_ok_d;

    vpa_decode u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    for (genvar s = 0; s < N_SIZE; s++) begin : g_size
        vpa_pair_lanes #(
            .VEC_W  (VEC_W),
            .ELEM_W (BASE_W << s)
        ) u_lanes (
            .src (in_src),
            .dst (in_dst),
            .uns (dec.uns),
            .acc (dec.acc),
            .res (lane_res[s])
        );
    end

    always_comb begin
        size_ok_d = (int'(dec.size) < N_SIZE);
        sel_res_d = '0;
        for (int s = 0; s < N_SIZE; s++) begin
            if (int'(dec.size) == s) sel_res_d = lane_res[s];
        end
        if (!dec.wide) sel_res_d[VEC_W-1:HALF_W] = '0;

        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.illegal = 1'b0;
        if (in_valid && dec.match) begin
            if (size_ok_d) begin
                st_d.valid  = 1'b1;
                st_d.result = sel_res_d;
                st_d.rn     = dec.rn;
                st_d.rd     = dec.rd;
            end else begin
                st_d.illegal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dec_match   = dec.match;
    assign out_valid   = st_q.valid;
    assign out_illegal = st_q.illegal;
    assign out_result  = st_q.result;
    assign out_rn      = st_q.rn;
    assign out_rd      = st_q.rd;

    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && dec_match));

    assert_illegal_excl_R8: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> !out_valid);

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_result));

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(in_insn[30])) |-> (out_result[VEC_W-1:HALF_W] == '0));
endmodule

// File: tb/sim_vpa_unit.sv
`timescale 1ns/1ps
module sim_vpa_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  in_insn = '0;
    logic [127:0] in_src = '0;
    logic [127:0] in_dst = '0;
    logic         dec_match, out_valid, out_illegal;
    logic [127:0] out_result;
    logic [4:0]   out_rn, out_rd;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vpa_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
        .in_src(in_src), .in_dst(in_dst), .dec_match(dec_match),
        .out_valid(out_valid), .out_illegal(out_illegal),
        .out_result(out_result), .out_rn(out_rn), .out_rd(out_rd)
    );

    function automatic logic [31:0] mk(logic q, logic u, logic [1:0] sz,
                                       logic a, logic [4:0] rn, logic [4:0] rd);
        return {1'b0, q, u, 5'b01110, sz, 1'b1, 5'b00000, 1'b0, a, 4'b1010, rn, rd};
    endfunction

    // independent reference built from the requirements
    function automatic logic [127:0] model(logic [31:0] w, logic [127:0] s, logic [127:0] d);
        int e;
        int n;
        logic [127:0] r;
        e = 8 << w[23:22];
        n = (w[30] ? 128 : 64) / (2 * e);
        r = '0;
        for (int p = 0; p < n; p++) begin
            logic [63:0] m, m2, a, b, c, sum;
            m  = (64'd1 << e) - 64'd1;
            m2 = (e == 32) ? {64{1'b1}} : ((64'd1 << (2 * e)) - 64'd1);
            a  = 64'(s >> (2 * p * e)) & m;
            b  = 64'(s >> ((2 * p + 1) * e)) & m;
            if (!w[29]) begin
                if (a[e-1]) a = a | ~m;
                if (b[e-1]) b = b | ~m;
            end
            c   = w[14] ? (64'(d >> (p * 2 * e)) & m2) : 64'd0;
            sum = (a + b + c) & m2;
            r   = r | (128'(sum) << (p * 2 * e));
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] w, logic [127:0] s, logic [127:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_insn = w; in_src = s; in_dst = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_op(string tag, logic [31:0] w, logic [127:0] s, logic [127:0] d);
        issue(w, s, d);
        chk({tag, " valid"}, 128'(out_valid), 128'd1);
        chk({tag, " result"}, out_result, model(w, s, d));
    endtask

    task automatic t_reset;
        chk("R11 valid", 128'(out_valid), 128'd0);
        chk("R11 illegal", 128'(out_illegal), 128'd0);
        chk("R11 result", out_result, 128'd0);
        chk("R11 rd", 128'(out_rd), 128'd0);
    endtask

    task automatic t_bytes;
        logic [127:0] ff = {128{1'b1}};
        // zero extension: 0xFF+0xFF = 0x01FE per halfword
        run_op("R2 R4 bytes unsigned", mk(1, 1, 0, 0, 3, 4), ff, '0);
        chk("R4 value", out_result, {8{16'h01FE}});
        // sign extension: -1 + -1 = 0xFFFE
        run_op("R3 bytes signed", mk(1, 0, 0, 0, 3, 4), ff, '0);
        chk("R3 value", out_result, {8{16'hFFFE}});
        run_op("R2 mixed", mk(1, 0, 0, 0, 1, 2),
               128'h80_7F_01_FF_12_34_90_10_00_05_7F_7F_81_80_C3_3C, '0);
    endtask

    task automatic t_accum;
        // 1+1+0xFFFF wraps to 0x0001
        run_op("R5 wrap", mk(1, 1, 0, 1, 0, 0), {16{8'h01}}, {128{1'b1}});
        chk("R5 wrap value", out_result, {8{16'h0001}});
        run_op("R5 mixed", mk(1, 0, 1, 1, 7, 8),
               128'h8000_7FFF_1234_FFFF_0001_8001_ABCD_0F0F,
               128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        run_op("R5 R7 64b acc", mk(1, 1, 2, 1, 9, 10),
               128'hFFFF_FFFF_FFFF_FFFF_8000_0000_8000_0000,
               128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0001);
    endtask

    task automatic t_sizes;
        run_op("R7 half signed", mk(1, 0, 1, 0, 2, 3), {16{8'hF0}}, '0);
        chk("R7 half signed value", out_result, {4{32'hFFFF_E1E0}});
        run_op("R7 word unsigned", mk(1, 1, 2, 0, 2, 3), {128{1'b1}}, '0);
        chk("R7 word unsigned value", out_result, {2{64'h0000_0001_FFFF_FFFE}});
        run_op("R7 word signed", mk(1, 0, 2, 0, 2, 3),
               128'h8000_0000_8000_0000_7FFF_FFFF_0000_0001, '0);
    endtask

    task automatic t_narrow;
        run_op("R6 bytes", mk(0, 1, 0, 1, 4, 5),
               128'hDEAD_BEEF_CAFE_F00D_0102_0304_0506_0708, {128{1'b1}});
        chk("R6 upper", out_result[127:64], 128'd0);
        run_op("R6 words", mk(0, 0, 2, 1, 4, 5),
               128'h1111_2222_3333_4444_8000_0000_FFFF_FFFF,
               128'h5555_6666_7777_8888_0000_0000_0000_0010);
    endtask

    task automatic t_illegal;
        logic [127:0] prev;
        run_op("R10 setup", mk(1, 1, 0, 0, 17, 30), {16{8'h22}}, '0);
        chk("R10 rd", 128'(out_rd), 128'd30);
        chk("R10 rn", 128'(out_rn), 128'd17);
        prev = out_result;
        issue(mk(1, 1, 3, 0, 1, 1), {128{1'b1}}, '0);
        chk("R8 illegal", 128'(out_illegal), 128'd1);
        chk("R8 no valid", 128'(out_valid), 128'd0);
        chk("R8 held", out_result, prev);
        @(negedge clk);
        chk("R9 idle valid", 128'(out_valid), 128'd0);
        chk("R9 idle illegal", 128'(out_illegal), 128'd0);
    endtask

    task automatic t_nomatch;
        logic [127:0] prev;
        logic [31:0] good;
        prev = out_result;
        good = mk(1, 0, 1, 1, 6, 6);
        @(negedge clk);
        in_insn = good; #0.5;
        chk("R1 match good", 128'(dec_match), 128'd1);
        in_insn = good | 32'h0000_0002 | 32'h0000_0080; #0.5;
        chk("R1 match free fields", 128'(dec_match), 128'd1);
        foreach (good[b]) begin
            if (b == 31 || (b >= 24 && b <= 28) || (b >= 15 && b <= 21) ||
                (b >= 10 && b <= 13)) begin
                in_insn = good ^ (32'd1 << b); #0.1;
                chk($sformatf("R1 flip bit %0d", b), 128'(dec_match), 128'd0);
            end
        end
        issue(good ^ 32'h0020_0000, {128{1'b1}}, {128{1'b1}});
        chk("R9 nomatch valid", 128'(out_valid), 128'd0);
        chk("R9 nomatch illegal", 128'(out_illegal), 128'd0);
        chk("R9 nomatch held", out_result, prev);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bytes();
        t_accum();
        t_sizes();
        t_narrow();
        t_illegal();
        t_nomatch();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule